// File: doc/BRIEF.md
# Boot Image Header and CRC Validator

This block inspects a second-stage boot image while it streams in, one byte per valid beat, beginning at image offset zero. It parses the program header that sits at offset 0x40, just after the exception-vector area. It checks the version and reserved bytes, verifies a 16-bit byte-sum checksum over the header, and bounds the declared image length. The bound depends on whether authentication is enabled. Across the image it runs a CRC-32 that is not bit-reflected and compares the result with the CRC word held in the last four bytes.

A loader pulses `start`, then feeds the image bytes. The block raises `done` once, after the byte that closes the image or at the first fault it detects. At that point `pass`, `err_code` and `entry_addr` are valid. They hold until the next `start`.

Header layout, with multi-byte fields little-endian:
- 0x40–0x43: validation word
- 0x44: version
- 0x45: flags
- 0x46–0x47: header length
- 0x48–0x4B: image length
- 0x4C–0x4F: entry offset
- 0x50–0x51: reserved
- 0x52–0x53: checksum

Top module: `boot_image_checker`

## Requirements
- R1: After synchronous reset `done` and `pass` are 0, `err_code` is 0 and `entry_addr` is 0.
- R2: A `start` pulse clears any previous result (`done`=0, `err_code`=0 in the next cycle) and restarts the check at image offset 0.
- R3: A version byte at offset 0x44 other than 0x01 ends the check with `err_code`=1.
- R4: A nonzero byte at offset 0x50 or 0x51 ends the check with `err_code`=2.
- R5: The 16-bit sum of bytes 0x40..0x51 must equal the little-endian checksum at 0x52..0x53, otherwise `err_code`=3.
- R6: The little-endian image length at 0x48..0x4B must be at least 0x58 and at most MAX_LEN_AUTH when `auth_en`=1, or MAX_LEN_PLAIN when `auth_en`=0. Otherwise `err_code`=4. Header faults are reported in the cycle after byte 0x53 is accepted, with priority 1 over 2 over 3 over 4.
- R7: The CRC (polynomial 0x04C11DB7, each byte fed MSB first, initial value 0xFFFFFFFF, result XORed with 0xFFFFFFFF) covers offsets 0 to length-5. It is compared with the little-endian word at offsets length-4..length-1; a mismatch gives `err_code`=5.
- R8: In the cycle after byte length-1 is accepted on a valid image, `done`=1, `pass`=1, `err_code`=0, and `entry_addr` equals HDR_BASE plus the little-endian entry offset at 0x4C..0x4F.
- R9: `in_last` on a valid byte before offset length-1 ends the check with `err_code`=6.
- R10: Beats with `in_valid`=0 are ignored whatever `in_byte` and `in_last` carry. Bytes arriving after `done` are ignored, and the result holds until `start`.
- R11: The validation word, flags and header-length bytes affect the result only through the checksum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a new check |
| auth_en | input | 1 | Selects the authenticated length bound |
| in_valid | input | 1 | `in_byte` carries an image byte this cycle |
| in_byte | input | 8 | Image byte |
| in_last | input | 1 | Marks the final byte the source will send |
| done | output | 1 | Result valid, held until `start` |
| pass | output | 1 | Image accepted |
| err_code | output | 3 | 0 none, 1 version, 2 reserved, 3 checksum, 4 length, 5 CRC, 6 early end |
| entry_addr | output | 32 | Entry address of an accepted image, else 0 |

## Verification
The length bounds are the hardest part to reach, because the default limits would need hundreds of thousands of streamed bytes to show an accepted image at the limit. The bench therefore instantiates the block with small limits. It then streams images exactly at and one byte past each bound, for both settings of `auth_en`. Invalid beats carrying `in_last` are interleaved into every stream, and junk bytes follow every result. This shows that neither disturbs the CRC offsets or the held outcome.

// File: rtl/boot_image_checker.sv
module boot_image_checker #(
  parameter int unsigned MAX_LEN_AUTH  = 212992,
  parameter int unsigned MAX_LEN_PLAIN = 229376,
  parameter logic [31:0] HDR_BASE      = 32'hFFE0_0040
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        auth_en,
  input  logic        in_valid,
  input  logic [7:0]  in_byte,
  input  logic        in_last,
  output logic        done,
  output logic        pass,
  output logic [2:0]  err_code,
  output logic [31:0] entry_addr
);
  localparam logic [31:0] POLY     = 32'h04C1_1DB7;
  localparam logic [31:0] HDR_OFF  = 32'h40;
  localparam logic [31:0] SUM_LAST = 32'h51;
  localparam logic [31:0] HDR_LAST = 32'h53;
  localparam logic [31:0] MIN_LEN  = HDR_LAST + 32'd5;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} st_t;
  st_t st;

  logic [31:0] off, crc, len, ent;
  logic [15:0] sum;
  logic [7:0]  ver, cks_lo;
  logic [23:0] tail;
  logic        rsv_nz;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    logic        fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[31] ^ d[i];
      r  = {r[30:0], 1'b0};
      if (fb) r = r ^ POLY;
    end
    return r;
  endfunction

  wire        beat    = (st == S_RUN) && in_valid && !start;
  wire [31:0] max_len = auth_en ? 32'(MAX_LEN_AUTH) : 32'(MAX_LEN_PLAIN);
  wire        in_crc  = (off <= HDR_LAST) || (off < len - 32'd4);
  wire        fin     = (off > HDR_LAST) && (off == len - 32'd1);
  wire [1:0]  tidx    = 2'(off - (len - 32'd4));
  wire        crc_ok  = ~crc == {in_byte, tail};

  logic [2:0] hdr_err;
  always_comb begin
    hdr_err = 3'd0;
    if (ver != 8'h01)                         hdr_err = 3'd1;
    else if (rsv_nz)                          hdr_err = 3'd2;
    else if (sum != {in_byte, cks_lo})        hdr_err = 3'd3;
    else if (len < MIN_LEN || len > max_len)  hdr_err = 3'd4;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; off <= '0; crc <= '1; len <= '0; ent <= '0; sum <= '0;
      ver <= '0; cks_lo <= '0; tail <= '0; rsv_nz <= 1'b0;
      done <= 1'b0; pass <= 1'b0; err_code <= 3'd0; entry_addr <= '0;
    end else if (start) begin
      st <= S_RUN; off <= '0; crc <= '1; len <= '0; ent <= '0; sum <= '0;
      ver <= '0; cks_lo <= '0; tail <= '0; rsv_nz <= 1'b0;
      done <= 1'b0; pass <= 1'b0; err_code <= 3'd0; entry_addr <= '0;
    end else if (beat) begin
      off <= off + 32'd1;
      if (in_crc) crc <= crc_step(crc, in_byte);
      else if (tidx != 2'd3) tail[8*tidx +: 8] <= in_byte;
      if (off >= HDR_OFF && off <= SUM_LAST) sum <= sum + 16'(in_byte);
      case (off)
        32'h44:                         ver <= in_byte;
        32'h48, 32'h49, 32'h4A, 32'h4B: len[8*off[1:0] +: 8] <= in_byte;
        32'h4C, 32'h4D, 32'h4E, 32'h4F: ent[8*off[1:0] +: 8] <= in_byte;
        32'h50, 32'h51:                 rsv_nz <= rsv_nz | (|in_byte);
        32'h52:                         cks_lo <= in_byte;
        default: ;
      endcase
      if (off == HDR_LAST && hdr_err != 3'd0) begin
        st <= S_DONE; done <= 1'b1; err_code <= hdr_err;
      end else if (fin) begin
        st <= S_DONE; done <= 1'b1;
        pass <= crc_ok;
        err_code <= crc_ok ? 3'd0 : 3'd5;
        entry_addr <= crc_ok ? HDR_BASE + ent : 32'd0;
      end else if (in_last) begin
        st <= S_DONE; done <= 1'b1; err_code <= 3'd6;
      end
    end
  end

  a_r2_start_clears: assert property (@(posedge clk) disable iff (rst)
    start |=> (!done && err_code == 3'd0));
  a_r10_result_held: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(err_code) && $stable(pass) && $stable(entry_addr)));
  a_r8_pass_means_clean: assert property (@(posedge clk) disable iff (rst)
    done |-> (pass == (err_code == 3'd0)));
  a_r1_quiet_until_done: assert property (@(posedge clk) disable iff (rst)
    !done |-> (err_code == 3'd0 && !pass && entry_addr == 32'd0));
  a_r10_gap_no_advance: assert property (@(posedge clk) disable iff (rst)
    (st == S_RUN && !in_valid && !start) |=> ($stable(off) && $stable(crc)));
  a_r6_len_floor: assert property (@(posedge clk) disable iff (rst)
    (done && pass) |-> (len >= MIN_LEN));
  a_r7_code_range: assert property (@(posedge clk) disable iff (rst)
    done |-> (err_code != 3'd7));
endmodule

// File: tb/boot_image_checker_bench.sv
`timescale 1ns/1ps
module boot_image_checker_bench;
  localparam int unsigned LIM_AUTH  = 200;
  localparam int unsigned LIM_PLAIN = 256;
  localparam logic [31:0] BASE      = 32'hFFE0_0040;
  localparam int          ISZ       = 320;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, auth_en = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic done, pass;
  logic [2:0] err_code;
  logic [31:0] entry_addr;

  int n_run = 0, n_fail = 0;

  typedef struct {
    logic [2:0]  err;
    logic        ok;
    logic [31:0] entry;
    string       tag;
  } exp_t;
  exp_t sb[$];

  logic [7:0] img [0:ISZ-1];

  always #2.5 clk = ~clk;

  boot_image_checker #(.MAX_LEN_AUTH(LIM_AUTH), .MAX_LEN_PLAIN(LIM_PLAIN), .HDR_BASE(BASE))
    u_boot_image_checker (.clk, .rst, .start, .auth_en, .in_valid, .in_byte, .in_last,
                          .done, .pass, .err_code, .entry_addr);

  function automatic logic [31:0] ref_crc(input int n);
    logic [31:0] c;
    logic fb;
    c = 32'hFFFF_FFFF;
    for (int k = 0; k < n; k++)
      for (int b = 7; b >= 0; b--) begin
        fb = c[31] ^ img[k][b];
        c  = {c[30:0], 1'b0} ^ (fb ? 32'h04C1_1DB7 : 32'h0);
      end
    return c ^ 32'hFFFF_FFFF;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  logic done_q = 1'b0;
  always @(negedge clk) begin
    if (!rst && done && !done_q) begin
      if (sb.size() == 0) check("R10 unexpected result", 32'd1, 32'd0);
      else begin
        exp_t e;
        e = sb.pop_front();
        check({e.tag, " err_code"}, 32'(err_code), 32'(e.err));
        check({e.tag, " pass"}, 32'(pass), 32'(e.ok));
        check({e.tag, " entry_addr"}, entry_addr, e.entry);
      end
    end
    done_q = done;
  end

  task automatic run_img(input string tag, input int len_f, input int n_send, input bit last,
                         input bit auth, input logic [7:0] ver, input logic [15:0] rsv,
                         input bit bad_cks, input bit bad_crc, input logic [31:0] ent,
                         input logic [7:0] flg, input logic [2:0] exp_err);
    logic [15:0] s;
    logic [31:0] c;
    exp_t e;
    for (int i = 0; i < ISZ; i++) img[i] = 8'((i * 7 + len_f) ^ 8'h3C);
    img[8'h40] = 8'h41 ^ flg; img[8'h41] = 8'h53; img[8'h42] = 8'h30; img[8'h43] = 8'h31;
    img[8'h44] = ver; img[8'h45] = flg; img[8'h46] = 8'h14 ^ flg; img[8'h47] = 8'h00;
    for (int b = 0; b < 4; b++) begin
      img[8'h48 + b] = 8'(len_f >> (8 * b));
      img[8'h4C + b] = 8'(ent >> (8 * b));
    end
    img[8'h50] = rsv[7:0]; img[8'h51] = rsv[15:8];
    s = 16'd0;
    for (int i = 8'h40; i <= 8'h51; i++) s = s + 16'(img[i]);
    if (bad_cks) s = s + 16'd1;
    img[8'h52] = s[7:0]; img[8'h53] = s[15:8];
    if (len_f >= 8'h58 && len_f <= ISZ) begin
      c = ref_crc(len_f - 4);
      if (bad_crc) c = c ^ 32'h0000_0100;
      for (int b = 0; b < 4; b++) img[len_f - 4 + b] = 8'(c >> (8 * b));
    end
    e.err = exp_err; e.ok = (exp_err == 3'd0);
    e.entry = (exp_err == 3'd0) ? BASE + ent : 32'd0; e.tag = tag;
    sb.push_back(e);

    auth_en = auth;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check({tag, " R2 done cleared"}, 32'(done), 32'd0);
    check({tag, " R2 err cleared"}, 32'(err_code), 32'd0);
    for (int i = 0; i < n_send; i++) begin
      if (i % 7 == 3) begin
        @(negedge clk); in_valid = 1'b0; in_byte = 8'h5A; in_last = 1'b1;
      end
      @(negedge clk); in_valid = 1'b1; in_byte = img[i]; in_last = last && (i == n_send - 1);
    end
    @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
    repeat (2) @(negedge clk);
    for (int j = 0; j < 3; j++) begin
      @(negedge clk); in_valid = 1'b1; in_byte = 8'hC3; in_last = 1'b1;
    end
    @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
    @(negedge clk);
    check({tag, " R10 done held"}, 32'(done), 32'd1);
    check({tag, " R10 err held"}, 32'(err_code), 32'(exp_err));
    check({tag, " R10 scoreboard drained"}, 32'(sb.size()), 32'd0);
  endtask

  initial begin
    fork
      begin
        repeat (60000) @(posedge clk);
        check("watchdog expired", 32'd1, 32'd0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 done", 32'(done), 32'd0);
    check("R1 pass", 32'(pass), 32'd0);
    check("R1 err", 32'(err_code), 32'd0);
    check("R1 entry", entry_addr, 32'd0);

    run_img("R7 R8 good plain",   120, 120, 1, 0, 8'h01, 16'h0, 0, 0, 32'h0000_0100, 8'h00, 3'd0);
    run_img("R6 R8 minimum len",  8'h58, 8'h58, 0, 1, 8'h01, 16'h0, 0, 0, 32'h0000_0054, 8'h00, 3'd0);
    run_img("R6 auth at limit",   200, 200, 1, 1, 8'h01, 16'h0, 0, 0, 32'h0001_2000, 8'h00, 3'd0);
    run_img("R6 auth over limit", 201, 8'h54, 0, 1, 8'h01, 16'h0, 0, 0, 32'h0, 8'h00, 3'd4);
    run_img("R6 plain 201 ok",    201, 201, 1, 0, 8'h01, 16'h0, 0, 0, 32'h0000_0080, 8'h00, 3'd0);
    run_img("R6 plain at limit",  256, 256, 1, 0, 8'h01, 16'h0, 0, 0, 32'hFFFF_FFC0, 8'h00, 3'd0);
    run_img("R6 plain over",      257, 8'h54, 0, 0, 8'h01, 16'h0, 0, 0, 32'h0, 8'h00, 3'd4);
    run_img("R6 below floor",     8'h57, 8'h54, 0, 0, 8'h01, 16'h0, 0, 0, 32'h0, 8'h00, 3'd4);
    run_img("R3 bad version",     120, 8'h54, 0, 0, 8'h02, 16'h0, 0, 0, 32'h0, 8'h00, 3'd1);
    run_img("R3 R6 priority",     999, 8'h54, 0, 0, 8'h00, 16'h0100, 1, 0, 32'h0, 8'h00, 3'd1);
    run_img("R4 reserved set",    120, 8'h54, 0, 0, 8'h01, 16'h0001, 0, 0, 32'h0, 8'h00, 3'd2);
    run_img("R4 R6 priority",     120, 8'h54, 0, 0, 8'h01, 16'h0100, 1, 0, 32'h0, 8'h00, 3'd2);
    run_img("R5 bad checksum",    120, 8'h54, 0, 0, 8'h01, 16'h0, 1, 0, 32'h0, 8'h00, 3'd3);
    run_img("R7 bad crc",         150, 150, 1, 0, 8'h01, 16'h0, 0, 1, 32'h0000_0100, 8'h00, 3'd5);
    run_img("R9 early end body",  100, 80, 1, 0, 8'h01, 16'h0, 0, 0, 32'h0, 8'h00, 3'd6);
    run_img("R9 early end hdr",   100, 8'h20, 1, 0, 8'h01, 16'h0, 0, 0, 32'h0, 8'h00, 3'd6);
    run_img("R11 fields ignored", 130, 130, 1, 0, 8'h01, 16'h0, 0, 0, 32'h0000_0040, 8'hFF, 3'd0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule